// File: doc/BRIEF.md
# Dual Chained Serial Word Output

This block sends result words out of a receive datapath over two independent one-bit serial lines, A and B. Seven 16-bit words arrive in parallel on a single bus: in-phase, quadrature, magnitude, phase, frequency, timing error and gain level. A one-cycle data-ready strobe marks a new set. Each line takes its own copy of the whole set when the strobe arrives. It then walks its own chain of words and shifts each word out most significant bit first, advancing one bit for each cycle in which the shared serial enable is high.

The chain for each line is static configuration. A start code names the first word. A link table gives, for every word type, the code of the word that follows it. A code of 7 ends the chain. Each line also has a sync output. Configuration places the sync either on the bit period of each word's most significant bit (leading) or on the bit period of its least significant bit (trailing), and gives it normal or inverted polarity. A strobe that arrives while a line is still shifting does not interrupt that line. The line reports the event on an overrun output instead.

Top module: `sdo_dual_port`

## Requirements
- R1: During and right after reset, both serial outputs are 0, both overrun outputs are 0, and each sync output sits at its inactive level (the value of that line's invert input).
- R2: Word codes are in-phase 0, quadrature 1, magnitude 2, phase 3, frequency 4, timing error 5 and gain level 6, and word k occupies bits [16k+15:16k] of the word bus. A strobe seen while a line is idle copies all seven words into that line, and later changes on the bus do not alter what the line sends.
- R3: The most significant bit of the first word appears on the serial output in the cycle after the strobe edge. Each later clock edge with the serial enable high moves the output to the next lower bit, and the output holds while the enable is low.
- R4: The link field for word k occupies bits [3k+2:3k] of a line's link input. After the last bit of word X, the line continues with the word that X's field names. A field of 7 ends the chain, and the serial output is 0 while the line is idle.
- R5: A link that names a word already sent in the current chain ends the chain, so a chain never sends more than seven words.
- R6: A start code of 7 keeps the line idle after a strobe, with no output activity.
- R7: With the lead input at 1, the sync is active during the most significant bit period of every word in the chain. With the lead input at 0, it is active during the least significant bit period.
- R8: With the invert input at 1, the sync output is the complement of its normal-polarity value, including while the line is idle.
- R9: A strobe that arrives while a line is shifting raises that line's overrun output for exactly the next cycle. The new set is dropped, and the current chain continues with its original data.
- R10: The two lines run independently. Different chains, sync options and lengths on A and B do not disturb each other, and an overrun on one line does not raise the other line's overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_rdy | input | 1 | One-cycle strobe: new word set on the bus |
| ser_en | input | 1 | Serial bit enable |
| word_bus | input | 112 | Seven 16-bit result words, word k at [16k+15:16k] |
| head_a | input | 3 | First word code for line A (7 = off) |
| links_a | input | 21 | Line A link table, field k at [3k+2:3k] |
| sync_lead_a | input | 1 | Line A sync on MSB (1) or LSB (0) |
| sync_inv_a | input | 1 | Line A sync inverted |
| head_b | input | 3 | First word code for line B (7 = off) |
| links_b | input | 21 | Line B link table |
| sync_lead_b | input | 1 | Line B sync on MSB (1) or LSB (0) |
| sync_inv_b | input | 1 | Line B sync inverted |
| ser_a | output | 1 | Line A serial data |
| sync_a | output | 1 | Line A sync |
| ovr_a | output | 1 | Line A overrun pulse |
| ser_b | output | 1 | Line B serial data |
| sync_b | output | 1 | Line B sync |
| ovr_b | output | 1 | Line B overrun pulse |

## Verification
Only one register stands between each input event and the output it causes. The first bit and its sync are due in the cycle after the strobe edge. Each enabled edge moves the line one bit, so bit position n of a chain is visible n cycles after the first bit when the enable is held high. An overrun pulse is due one cycle after the offending strobe and lasts one cycle. The bench drives inputs on falling edges and samples on falling edges, and it tracks the bit position by counting the rising edges since the strobe. This makes every expected value fall on a known cycle.

// File: rtl/sdo_pkg.sv
package sdo_pkg;
   localparam int unsigned SDO_WORD_W = 16;
   localparam int unsigned SDO_NWORDS = 7;
   localparam int unsigned SDO_NLANES = 2;

   typedef enum logic [2:0] {
      WC_I   = 3'd0,
      WC_Q   = 3'd1,
      WC_MAG = 3'd2,
      WC_PHS = 3'd3,
      WC_FRQ = 3'd4,
      WC_TE  = 3'd5,
      WC_AGC = 3'd6,
      WC_END = 3'd7
   } word_code_e;
endpackage

// File: rtl/sdo_chain_seq.sv
module sdo_chain_seq #(
   parameter int unsigned NWORDS = 7,
   parameter int unsigned WORD_W = 16,
   localparam int unsigned CODE_W = $clog2(NWORDS + 1),
   localparam int unsigned BIT_W  = $clog2(WORD_W)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     bit_en,
   input  logic [CODE_W-1:0]        head,
   input  logic [NWORDS*CODE_W-1:0] links,
   output logic                     active,
   output logic [CODE_W-1:0]        cur,
   output logic [BIT_W-1:0]         bit_idx
);
   localparam logic [CODE_W-1:0] END_CODE = CODE_W'(NWORDS);
   localparam logic [BIT_W-1:0]  TOP_BIT  = BIT_W'(WORD_W - 1);

   logic [NWORDS-1:0] visited;
   logic [CODE_W-1:0] nxt;
   logic              nxt_ok;

   // next word named by the link field of the word now shifting
   always_comb begin
      nxt    = END_CODE;
      nxt_ok = 1'b0;
      if (cur < END_CODE) begin
         nxt = links[cur*CODE_W +: CODE_W];
         if (nxt < END_CODE) begin
            nxt_ok = !visited[nxt];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         cur     <= '0;
         visited <= '0;
         bit_idx <= '0;
      end else if (!active) begin
         if (start && (head < END_CODE)) begin
            active  <= 1'b1;
            cur     <= head;
            visited <= NWORDS'(1) << head;
            bit_idx <= TOP_BIT;
         end
      end else if (bit_en) begin
         if (bit_idx != '0) begin
            bit_idx <= bit_idx - 1'b1;
         end else if (nxt_ok) begin
            cur     <= nxt;
            visited <= visited | (NWORDS'(1) << nxt);
            bit_idx <= TOP_BIT;
         end else begin
            active <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sdo_lane.sv
module sdo_lane #(
   parameter int unsigned NWORDS = 7,
   parameter int unsigned WORD_W = 16,
   localparam int unsigned CODE_W = $clog2(NWORDS + 1),
   localparam int unsigned BIT_W  = $clog2(WORD_W)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     data_rdy,
   input  logic                     bit_en,
   input  logic [NWORDS*WORD_W-1:0] word_bus,
   input  logic [CODE_W-1:0]        head,
   input  logic [NWORDS*CODE_W-1:0] links,
   input  logic                     sync_lead,
   input  logic                     sync_inv,
   output logic                     ser,
   output logic                     sync,
   output logic                     ovr,
   output logic                     busy
);
   localparam logic [CODE_W-1:0] END_CODE = CODE_W'(NWORDS);
   localparam logic [BIT_W-1:0]  TOP_BIT  = BIT_W'(WORD_W - 1);

   logic [NWORDS*WORD_W-1:0] snap;
   logic [WORD_W-1:0]        snap_w [NWORDS];
   logic [CODE_W-1:0]        cur;
   logic [BIT_W-1:0]         bit_idx;
   logic                     active;
   logic                     sync_raw;

   sdo_chain_seq #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (data_rdy),
      .bit_en  (bit_en),
      .head    (head),
      .links   (links),
      .active  (active),
      .cur     (cur),
      .bit_idx (bit_idx)
   );

   // private copy of the set, taken only while idle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap <= '0;
         ovr  <= 1'b0;
      end else begin
         ovr <= data_rdy && active;
         if (data_rdy && !active) begin
            snap <= word_bus;
         end
      end
   end

   for (genvar k = 0; k < NWORDS; k++) begin : g_split
      assign snap_w[k] = snap[k*WORD_W +: WORD_W];
   end

   always_comb begin
      ser      = 1'b0;
      sync_raw = 1'b0;
      if (active && (cur < END_CODE)) begin
         ser      = snap_w[cur][bit_idx];
         sync_raw = sync_lead ? (bit_idx == TOP_BIT) : (bit_idx == '0);
      end
   end

   assign sync = sync_raw ^ sync_inv;
   assign busy = active;
endmodule

// File: rtl/sdo_dual_port.sv
module sdo_dual_port
   import sdo_pkg::*;
#(
   parameter int unsigned NWORDS = SDO_NWORDS,
   parameter int unsigned WORD_W = SDO_WORD_W,
   localparam int unsigned CODE_W = $clog2(NWORDS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     data_rdy,
   input  logic                     ser_en,
   input  logic [NWORDS*WORD_W-1:0] word_bus,
   input  logic [CODE_W-1:0]        head_a,
   input  logic [NWORDS*CODE_W-1:0] links_a,
   input  logic                     sync_lead_a,
   input  logic                     sync_inv_a,
   input  logic [CODE_W-1:0]        head_b,
   input  logic [NWORDS*CODE_W-1:0] links_b,
   input  logic                     sync_lead_b,
   input  logic                     sync_inv_b,
   output logic                     ser_a,
   output logic                     sync_a,
   output logic                     ovr_a,
   output logic                     ser_b,
   output logic                     sync_b,
   output logic                     ovr_b
);
   if (WORD_W < 2) begin : g_bad_width
      $error("sdo_dual_port: WORD_W must be at least 2");
   end
   if (NWORDS < 1) begin : g_bad_count
      $error("sdo_dual_port: NWORDS must be at least 1");
   end

   logic [CODE_W-1:0]        head_l  [SDO_NLANES];
   logic [NWORDS*CODE_W-1:0] links_l [SDO_NLANES];
   logic [SDO_NLANES-1:0]    lead_l, inv_l, ser_l, sync_l, ovr_l, busy_l;

   assign head_l[0]  = head_a;
   assign head_l[1]  = head_b;
   assign links_l[0] = links_a;
   assign links_l[1] = links_b;
   assign lead_l     = {sync_lead_b, sync_lead_a};
   assign inv_l      = {sync_inv_b, sync_inv_a};

   for (genvar l = 0; l < SDO_NLANES; l++) begin : g_lane
      sdo_lane #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .data_rdy  (data_rdy),
         .bit_en    (ser_en),
         .word_bus  (word_bus),
         .head      (head_l[l]),
         .links     (links_l[l]),
         .sync_lead (lead_l[l]),
         .sync_inv  (inv_l[l]),
         .ser       (ser_l[l]),
         .sync      (sync_l[l]),
         .ovr       (ovr_l[l]),
         .busy      (busy_l[l])
      );
   end

   assign ser_a  = ser_l[0];
   assign sync_a = sync_l[0];
   assign ovr_a  = ovr_l[0];
   assign ser_b  = ser_l[1];
   assign sync_b = sync_l[1];
   assign ovr_b  = ovr_l[1];
endmodule

// File: rtl/sdo_dual_port_chk.sv
module sdo_dual_port_chk #(
   parameter int unsigned NWORDS = 7,
   localparam int unsigned CODE_W = $clog2(NWORDS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              data_rdy,
   input logic              ser_en,
   input logic [CODE_W-1:0] head_a,
   input logic [CODE_W-1:0] head_b,
   input logic              sync_inv_a,
   input logic              sync_inv_b,
   input logic              ser_a,
   input logic              ser_b,
   input logic              sync_a,
   input logic              sync_b,
   input logic              ovr_a,
   input logic              ovr_b,
   input logic [1:0]        busy_l
);
   localparam logic [CODE_W-1:0] END_CODE = CODE_W'(NWORDS);

   AST_OVR_CAUSE_A: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_a |-> $past(data_rdy && busy_l[0])); // R9
   AST_OVR_CAUSE_B: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_b |-> $past(data_rdy && busy_l[1])); // R10
   AST_IDLE_SER_A: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_l[0] |-> !ser_a); // R4
   AST_IDLE_SER_B: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_l[1] |-> !ser_b); // R4
   AST_IDLE_SYNC_A: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_l[0] |-> (sync_a == sync_inv_a)); // R8
   AST_IDLE_SYNC_B: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_l[1] |-> (sync_b == sync_inv_b)); // R8
   AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_l[0] && !ser_en) |=> $stable(ser_a)); // R3
   AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_l[1] && !ser_en) |=> $stable(ser_b)); // R3
   AST_START_A: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_l[0] && data_rdy && (head_a < END_CODE)) |=> busy_l[0]); // R2
   AST_OFF_B: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_l[1] && (head_b == END_CODE)) |=> !busy_l[1]); // R6
endmodule

bind sdo_dual_port sdo_dual_port_chk #(.NWORDS(NWORDS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .data_rdy   (data_rdy),
   .ser_en     (ser_en),
   .head_a     (head_a),
   .head_b     (head_b),
   .sync_inv_a (sync_inv_a),
   .sync_inv_b (sync_inv_b),
   .ser_a      (ser_a),
   .ser_b      (ser_b),
   .sync_a     (sync_a),
   .sync_b     (sync_b),
   .ovr_a      (ovr_a),
   .ovr_b      (ovr_b),
   .busy_l     (busy_l)
);

// File: tb/test_sdo_dual_port.sv
module test_sdo_dual_port;
   localparam int NW = 7;
   localparam int WW = 16;

   function automatic logic [20:0] mk(input int l0, l1, l2, l3, l4, l5, l6);
      return {3'(l6), 3'(l5), 3'(l4), 3'(l3), 3'(l2), 3'(l1), 3'(l0)};
   endfunction

   typedef struct packed {
      logic [2:0]  ha;
      logic [20:0] la;
      logic        da;
      logic        ia;
      logic [3:0]  na;
      logic [2:0]  hb;
      logic [20:0] lb;
      logic        db;
      logic        ib;
      logic [3:0]  nb;
   } vec_t;

   // head, links, lead, invert, expected word count; line A then line B
   localparam vec_t VECS [4] = '{
      '{3'd0, mk(1,7,7,7,7,7,7), 1'b1, 1'b0, 4'd2,
        3'd2, mk(7,7,3,7,7,7,7), 1'b0, 1'b1, 4'd2},
      '{3'd3, mk(7,7,7,4,5,6,7), 1'b0, 1'b1, 4'd4,
        3'd7, mk(7,7,7,7,7,7,7), 1'b1, 1'b0, 4'd0},
      '{3'd0, mk(1,0,7,7,7,7,7), 1'b1, 1'b1, 4'd2,
        3'd6, mk(7,7,7,7,7,7,6), 1'b0, 1'b0, 4'd1},
      '{3'd0, mk(1,2,3,4,5,6,7), 1'b1, 1'b0, 4'd7,
        3'd1, mk(7,0,7,7,7,7,7), 1'b0, 1'b1, 4'd2}
   };

   logic clk = 1'b0, rst_n = 1'b0, data_rdy = 1'b0, ser_en = 1'b0;
   logic [NW*WW-1:0] word_bus = '0;
   logic [2:0]  head_a = 3'd7, head_b = 3'd7;
   logic [20:0] links_a = '1, links_b = '1;
   logic sync_lead_a = 1'b1, sync_inv_a = 1'b0, sync_lead_b = 1'b1, sync_inv_b = 1'b1;
   logic ser_a, sync_a, ovr_a, ser_b, sync_b, ovr_b;
   int n_chk = 0, n_err = 0;

   always #10 clk = ~clk;

   sdo_dual_port i_sdo_dual_port (
      .clk(clk), .rst_n(rst_n), .data_rdy(data_rdy), .ser_en(ser_en),
      .word_bus(word_bus),
      .head_a(head_a), .links_a(links_a), .sync_lead_a(sync_lead_a), .sync_inv_a(sync_inv_a),
      .head_b(head_b), .links_b(links_b), .sync_lead_b(sync_lead_b), .sync_inv_b(sync_inv_b),
      .ser_a(ser_a), .sync_a(sync_a), .ovr_a(ovr_a),
      .ser_b(ser_b), .sync_b(sync_b), .ovr_b(ovr_b)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] wv(input int v, input int k);
      return 16'((k + 1) * 16'h2B63 ^ (v * 16'h0F31) ^ 16'h8000 * (k % 2));
   endfunction

   function automatic int walk(input logic [2:0] h, input logic [20:0] l, input int idx);
      int c = h;
      for (int i = 0; i < idx; i++) c = l[c*3 +: 3];
      return c;
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic strobe();
      data_rdy = 1'b1;
      step();
      data_rdy = 1'b0;
   endtask

   task automatic run_vec(input int v);
      vec_t t = VECS[v];
      int bad_sa = 0, bad_ya = 0, bad_sb = 0, bad_yb = 0;
      int fa = -1, fb = -1;
      head_a = t.ha; links_a = t.la; sync_lead_a = t.da; sync_inv_a = t.ia;
      head_b = t.hb; links_b = t.lb; sync_lead_b = t.db; sync_inv_b = t.ib;
      for (int k = 0; k < NW; k++) word_bus[k*WW +: WW] = wv(v, k);
      ser_en = 1'b1;
      strobe();
      for (int n = 0; n < NW*WW + 2; n++) begin
         logic ea, eb, ya, yb;
         ea = 1'b0; eb = 1'b0; ya = 1'b0; yb = 1'b0;
         if (n < int'(t.na) * WW) begin
            ea = wv(v, walk(t.ha, t.la, n / WW))[WW-1 - n % WW];
            ya = t.da ? (n % WW == 0) : (n % WW == WW-1);
         end
         if (n < int'(t.nb) * WW) begin
            eb = wv(v, walk(t.hb, t.lb, n / WW))[WW-1 - n % WW];
            yb = t.db ? (n % WW == 0) : (n % WW == WW-1);
         end
         ya ^= t.ia; yb ^= t.ib;
         if (ser_a !== ea) begin bad_sa++; if (fa < 0) fa = n; end
         if (sync_a !== ya) bad_ya++;
         if (ser_b !== eb) begin bad_sb++; if (fb < 0) fb = n; end
         if (sync_b !== yb) bad_yb++;
         step();
      end
      // R2 R3 R4 R5 R6 R10: bit stream; R7 R8: sync position and level
      chk(bad_sa == 0, $sformatf("R4 R5 vec%0d line A bits, first bad pos", v), fa, -1);
      chk(bad_ya == 0, $sformatf("R7 R8 vec%0d line A sync mismatches", v), bad_ya, 0);
      chk(bad_sb == 0, $sformatf("R6 R10 vec%0d line B bits, first bad pos", v), fb, -1);
      chk(bad_yb == 0, $sformatf("R7 R8 vec%0d line B sync mismatches", v), bad_yb, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(ser_a == 0 && ser_b == 0, "R1 serial idle in reset", {ser_b, ser_a}, 0);
      chk(sync_a == 0 && sync_b == 1, "R1 sync inactive levels", {sync_b, sync_a}, 2);
      rst_n = 1'b1;
      step();
      chk(ovr_a == 0 && ovr_b == 0 && ser_a == 0, "R1 after reset", {ovr_b, ovr_a, ser_a}, 0);

      for (int v = 0; v < 4; v++) run_vec(v);

      // R3: hold while enable low
      head_a = 3'd0; links_a = mk(7,7,7,7,7,7,7); sync_lead_a = 1'b1; sync_inv_a = 1'b0;
      head_b = 3'd7; word_bus[15:0] = 16'h8001; ser_en = 1'b0;
      strobe();
      chk(ser_a == 1 && sync_a == 1, "R3 MSB after strobe", {ser_a, sync_a}, 3);
      repeat (3) step();
      chk(ser_a == 1 && sync_a == 1, "R3 hold with enable low", {ser_a, sync_a}, 3);
      ser_en = 1'b1;
      step();
      ser_en = 1'b0;
      chk(ser_a == 0 && sync_a == 0, "R3 one bit per enable", {ser_a, sync_a}, 0);
      ser_en = 1'b1;
      repeat (14) step();
      chk(ser_a == 1 && sync_a == 0, "R3 LSB reached", {ser_a, sync_a}, 2);
      step();
      chk(ser_a == 0, "R4 idle after end code", ser_a, 0);

      // R9 R2: overrun drops the new set, old chain continues
      head_a = 3'd1; links_a = mk(7,7,7,7,7,7,7); sync_lead_a = 1'b0;
      word_bus[31:16] = 16'hC3A5;
      strobe();
      repeat (3) step();
      word_bus[31:16] = 16'h0000;
      data_rdy = 1'b1;
      step();
      data_rdy = 1'b0;
      chk(ovr_a == 1, "R9 overrun pulse", ovr_a, 1);
      chk(ovr_b == 0, "R10 other line no overrun", ovr_b, 0);
      chk(ser_a == 1'(16'hC3A5 >> 11), "R9 stream keeps old data bit 11", ser_a, 1'(16'hC3A5 >> 11));
      step();
      chk(ovr_a == 0, "R9 overrun lasts one cycle", ovr_a, 0);
      repeat (10) step();
      chk(ser_a == 1'(16'hC3A5) && sync_a == 1, "R2 R7 LSB of old word, trailing sync", {ser_a, sync_a}, {1'(16'hC3A5), 1'b1});
      step();
      chk(ser_a == 0 && sync_a == 0, "R4 idle after dropped set", {ser_a, sync_a}, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule